// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block produces the two source operands for the instruction sitting in the decode stage of a five-stage in-order pipeline. Instructions ahead of it in execute, memory and write-back may hold results that have not yet reached the register file. For each operand, the block compares the decode source register ID with every destination ID in flight. It then takes the value from the youngest matching producer, or uses the register-file read value when nothing matches.

Each later stage offers up to two results. Execute offers only the value its ALU is computing in the current cycle. Memory and write-back each offer a loaded value and an ALU result. Operand A has one extra case: a call or jump in decode takes its own incremented PC as operand A, ahead of any forwarding. The block is purely combinational. Stall and bubble control, the register file, the ALU and the data memory sit outside it.

Top module: `opnd_bypass_sel`

## Requirements
- R1: When `dec_op` is the call code (4'h8) or the jump code (4'h7), `opnd_a` equals `dec_pc_next`, whatever the register IDs are.
- R2: Otherwise `opnd_a` is taken from the first matching source in this order: execute ALU value, memory loaded value, memory ALU result, write-back loaded value, write-back ALU result.
- R3: A source counts as matching only when its destination ID equals the decode source ID exactly.
- R4: When no source matches, each operand equals its register-file read value (`rf_val_a` / `rf_val_b`).
- R5: `opnd_b` follows the same priority chain as R2 using `dec_src_b`. A call or jump opcode has no effect on it.
- R6: Register ID 4'hF means "no register". It never produces a match, even when a destination also carries 4'hF.
- R7: When one register is the destination in several stages at once, the youngest stage wins. Within memory and within write-back, the loaded value beats the ALU result.
- R8: Both outputs respond to input changes with no clock. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Opcode of the decode-stage instruction |
| dec_src_a | input | 4 | Source register ID for operand A |
| dec_src_b | input | 4 | Source register ID for operand B |
| rf_val_a | input | 32 | Register-file read value for operand A |
| rf_val_b | input | 32 | Register-file read value for operand B |
| dec_pc_next | input | 32 | Incremented PC of the decode instruction |
| ex_dst_alu | input | 4 | Destination ID of the execute-stage ALU result |
| ex_alu_val | input | 32 | ALU value being computed in execute this cycle |
| mem_dst_load | input | 4 | Destination ID of the memory-stage loaded value |
| mem_load_val | input | 32 | Value loaded in the memory stage |
| mem_dst_alu | input | 4 | Destination ID of the memory-stage ALU result |
| mem_alu_val | input | 32 | ALU result carried in the memory stage |
| wb_dst_load | input | 4 | Destination ID of the write-back loaded value |
| wb_load_val | input | 32 | Loaded value carried in write-back |
| wb_dst_alu | input | 4 | Destination ID of the write-back ALU result |
| wb_alu_val | input | 32 | ALU result carried in write-back |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
Two behaviours can apply in the same evaluation, and the tests target both overlaps.

- **Call/jump override with forwarding:** a call or jump opcode is driven while one or more stages hold a matching destination for operand A. The PC must win on A while B still forwards normally.
- **Several matching stages:** one register ID is placed as the destination in every stage slot together. Slots are then removed one by one, and the expected winner moves down the priority list.

Random stimulus draws register IDs from a narrow set that includes 4'hF. This makes partial overlaps frequent. Every result is compared against a bench model of the priority order.

// File: rtl/fwd_sel_pkg.sv
package fwd_sel_pkg;
  // number of forwarding slots, youngest first
  localparam int NSRC = 5;
  localparam int SLOT_EX_ALU   = 0;
  localparam int SLOT_MEM_LOAD = 1;
  localparam int SLOT_MEM_ALU  = 2;
  localparam int SLOT_WB_LOAD  = 3;
  localparam int SLOT_WB_ALU   = 4;

  // keep only the lowest-index (youngest) set bit
  function automatic logic [NSRC-1:0] first_hit(input logic [NSRC-1:0] hits);
    logic [NSRC-1:0] res;
    logic found;
    res = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (hits[i] && !found) begin
        res[i] = 1'b1;
        found = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/fwd_id_cmp.sv
module fwd_id_cmp #(
  parameter int RW = 4,
  parameter logic [RW-1:0] NONE_ID = '1
) (
  input  logic [RW-1:0] src_id,
  input  logic [RW-1:0] dst_id,
  output logic          hit
);
  logic src_real;
  assign src_real = (src_id != NONE_ID);
  assign hit = src_real && (src_id == dst_id);
endmodule

// File: rtl/fwd_chain.sv
module fwd_chain
  import fwd_sel_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 4,
  parameter logic [RW-1:0] NONE_ID = '1
) (
  input  logic [RW-1:0]            src_id,
  input  logic                     pc_sel,
  input  logic [DW-1:0]            pc_val,
  input  logic [NSRC-1:0][RW-1:0]  dst_ids,
  input  logic [NSRC-1:0][DW-1:0]  vals,
  input  logic [DW-1:0]            rf_val,
  output logic [NSRC-1:0]          hit_vec,
  output logic [NSRC-1:0]          pick_vec,
  output logic [DW-1:0]            result
);
  logic [DW-1:0] fwd_val;

  for (genvar s = 0; s < NSRC; s++) begin : g_cmp
    fwd_id_cmp #(.RW(RW), .NONE_ID(NONE_ID)) u_cmp (
      .src_id(src_id),
      .dst_id(dst_ids[s]),
      .hit   (hit_vec[s])
    );
  end

  assign pick_vec = first_hit(hit_vec);

  always_comb begin
    fwd_val = '0;
    for (int s = 0; s < NSRC; s++) begin
      fwd_val = fwd_val | (vals[s] & {DW{pick_vec[s]}});
    end
  end

  always_comb begin
    if (pc_sel)              result = pc_val;
    else if (|pick_vec)      result = fwd_val;
    else                     result = rf_val;
  end
endmodule

// File: rtl/opnd_bypass_sel.sv
module opnd_bypass_sel
  import fwd_sel_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 4,
  parameter int OPW = 4,
  parameter logic [OPW-1:0] CALL_OP = 4'h8,
  parameter logic [OPW-1:0] JUMP_OP = 4'h7,
  parameter logic [RW-1:0]  NONE_ID = 4'hF
) (
  input  logic [OPW-1:0] dec_op,
  input  logic [RW-1:0]  dec_src_a,
  input  logic [RW-1:0]  dec_src_b,
  input  logic [DW-1:0]  rf_val_a,
  input  logic [DW-1:0]  rf_val_b,
  input  logic [DW-1:0]  dec_pc_next,
  input  logic [RW-1:0]  ex_dst_alu,
  input  logic [DW-1:0]  ex_alu_val,
  input  logic [RW-1:0]  mem_dst_load,
  input  logic [DW-1:0]  mem_load_val,
  input  logic [RW-1:0]  mem_dst_alu,
  input  logic [DW-1:0]  mem_alu_val,
  input  logic [RW-1:0]  wb_dst_load,
  input  logic [DW-1:0]  wb_load_val,
  input  logic [RW-1:0]  wb_dst_alu,
  input  logic [DW-1:0]  wb_alu_val,
  output logic [DW-1:0]  opnd_a,
  output logic [DW-1:0]  opnd_b
);
  logic [NSRC-1:0][RW-1:0] dst_ids;
  logic [NSRC-1:0][DW-1:0] src_vals;
  logic                    is_ctl;
  logic [NSRC-1:0]         a_hit, a_pick, b_hit, b_pick;

  assign dst_ids[SLOT_EX_ALU]   = ex_dst_alu;
  assign dst_ids[SLOT_MEM_LOAD] = mem_dst_load;
  assign dst_ids[SLOT_MEM_ALU]  = mem_dst_alu;
  assign dst_ids[SLOT_WB_LOAD]  = wb_dst_load;
  assign dst_ids[SLOT_WB_ALU]   = wb_dst_alu;

  assign src_vals[SLOT_EX_ALU]   = ex_alu_val;
  assign src_vals[SLOT_MEM_LOAD] = mem_load_val;
  assign src_vals[SLOT_MEM_ALU]  = mem_alu_val;
  assign src_vals[SLOT_WB_LOAD]  = wb_load_val;
  assign src_vals[SLOT_WB_ALU]   = wb_alu_val;

  assign is_ctl = (dec_op == CALL_OP) || (dec_op == JUMP_OP);

  fwd_chain #(.DW(DW), .RW(RW), .NONE_ID(NONE_ID)) u_chain_a (
    .src_id  (dec_src_a),
    .pc_sel  (is_ctl),
    .pc_val  (dec_pc_next),
    .dst_ids (dst_ids),
    .vals    (src_vals),
    .rf_val  (rf_val_a),
    .hit_vec (a_hit),
    .pick_vec(a_pick),
    .result  (opnd_a)
  );

  fwd_chain #(.DW(DW), .RW(RW), .NONE_ID(NONE_ID)) u_chain_b (
    .src_id  (dec_src_b),
    .pc_sel  (1'b0),
    .pc_val  (dec_pc_next),
    .dst_ids (dst_ids),
    .vals    (src_vals),
    .rf_val  (rf_val_b),
    .hit_vec (b_hit),
    .pick_vec(b_pick),
    .result  (opnd_b)
  );
endmodule

// File: rtl/fwd_sel_chk.sv
module fwd_sel_chk #(
  parameter int DW = 32,
  parameter int RW = 4,
  parameter int OPW = 4,
  parameter int NS = 5,
  parameter logic [RW-1:0] NONE_ID = 4'hF
) (
  input logic           is_ctl,
  input logic [NS-1:0]  a_hit,
  input logic [NS-1:0]  a_pick,
  input logic [NS-1:0]  b_pick,
  input logic [RW-1:0]  dec_src_a,
  input logic [RW-1:0]  dec_src_b,
  input logic [DW-1:0]  rf_val_b,
  input logic [DW-1:0]  dec_pc_next,
  input logic [RW-1:0]  ex_dst_alu,
  input logic [DW-1:0]  ex_alu_val,
  input logic [RW-1:0]  mem_dst_load,
  input logic [RW-1:0]  mem_dst_alu,
  input logic [RW-1:0]  wb_dst_load,
  input logic [RW-1:0]  wb_dst_alu,
  input logic [DW-1:0]  opnd_a,
  input logic [DW-1:0]  opnd_b
);
  logic known;
  logic b_any;
  assign known = !$isunknown({is_ctl, a_pick, b_pick, dec_src_a, dec_src_b, ex_dst_alu,
                              mem_dst_load, mem_dst_alu, wb_dst_load, wb_dst_alu});
  assign b_any = (dec_src_b != NONE_ID) &&
                 (dec_src_b == ex_dst_alu || dec_src_b == mem_dst_load ||
                  dec_src_b == mem_dst_alu || dec_src_b == wb_dst_load ||
                  dec_src_b == wb_dst_alu);

  always_comb begin
    if (known) begin
      // R1
      pc_override_chk: assert (!is_ctl || opnd_a == dec_pc_next);
      // R7
      ex_youngest_chk: assert (is_ctl || dec_src_a == NONE_ID || dec_src_a != ex_dst_alu
                               || opnd_a == ex_alu_val);
      // R2
      single_pick_a_chk: assert ($onehot0(a_pick));
      // R5
      single_pick_b_chk: assert ($onehot0(b_pick));
      // R4
      rf_fallback_b_chk: assert (b_any || opnd_b == rf_val_b);
      // R6
      none_id_chk: assert (dec_src_a != NONE_ID || a_hit == '0);
    end
  end
endmodule

bind opnd_bypass_sel fwd_sel_chk #(
  .DW(DW), .RW(RW), .OPW(OPW), .NS(fwd_sel_pkg::NSRC), .NONE_ID(NONE_ID)
) u_fwd_sel_chk (
  .is_ctl      (is_ctl),
  .a_hit       (a_hit),
  .a_pick      (a_pick),
  .b_pick      (b_pick),
  .dec_src_a   (dec_src_a),
  .dec_src_b   (dec_src_b),
  .rf_val_b    (rf_val_b),
  .dec_pc_next (dec_pc_next),
  .ex_dst_alu  (ex_dst_alu),
  .ex_alu_val  (ex_alu_val),
  .mem_dst_load(mem_dst_load),
  .mem_dst_alu (mem_dst_alu),
  .wb_dst_load (wb_dst_load),
  .wb_dst_alu  (wb_dst_alu),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b)
);

// File: tb/tb_opnd_bypass_sel.sv
`timescale 1ns/1ps
module tb_opnd_bypass_sel;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [3:0]  dec_op, dec_src_a, dec_src_b;
  logic [31:0] rf_val_a, rf_val_b, dec_pc_next;
  logic [3:0]  ex_dst_alu, mem_dst_load, mem_dst_alu, wb_dst_load, wb_dst_alu;
  logic [31:0] ex_alu_val, mem_load_val, mem_alu_val, wb_load_val, wb_alu_val;
  logic [31:0] opnd_a, opnd_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  opnd_bypass_sel dut (.*);

  // bench model: youngest-first list written as explicit if-chain
  function automatic logic [31:0] model(input bit is_a, input logic [3:0] src,
                                        input logic [31:0] rf);
    if (is_a && (dec_op == 4'h8 || dec_op == 4'h7)) return dec_pc_next;
    if (src == 4'hF) return rf;
    if (src == ex_dst_alu)   return ex_alu_val;
    if (src == mem_dst_load) return mem_load_val;
    if (src == mem_dst_alu)  return mem_alu_val;
    if (src == wb_dst_load)  return wb_load_val;
    if (src == wb_dst_alu)   return wb_alu_val;
    return rf;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic settle_and_check(input string req);
    @(negedge clk);
    check({req, " A"}, opnd_a, model(1'b1, dec_src_a, rf_val_a));
    check({req, " B"}, opnd_b, model(1'b0, dec_src_b, rf_val_b));
  endtask

  task automatic base();
    dec_op = 4'h2; dec_src_a = 4'h1; dec_src_b = 4'h2;
    rf_val_a = 32'hAAAA_0001; rf_val_b = 32'hBBBB_0002; dec_pc_next = 32'h0000_1004;
    ex_dst_alu = 4'hF; mem_dst_load = 4'hF; mem_dst_alu = 4'hF;
    wb_dst_load = 4'hF; wb_dst_alu = 4'hF;
    ex_alu_val = 32'h1111_0000; mem_load_val = 32'h2222_0000; mem_alu_val = 32'h3333_0000;
    wb_load_val = 32'h4444_0000; wb_alu_val = 32'h5555_0000;
  endtask

  function automatic logic [3:0] pick_id();
    logic [2:0] r = 3'($urandom_range(0, 4));
    return (r == 3'd4) ? 4'hF : {2'b00, r[1:0]};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    base();
    // R4: nothing in flight matches
    @(negedge clk);
    check("R4 A rf", opnd_a, 32'hAAAA_0001);
    check("R4 B rf", opnd_b, 32'hBBBB_0002);

    // R7 / R2: register 1 targeted by all slots, peel from youngest
    ex_dst_alu = 4'h1; mem_dst_load = 4'h1; mem_dst_alu = 4'h1;
    wb_dst_load = 4'h1; wb_dst_alu = 4'h1;
    @(negedge clk); check("R7 ex wins", opnd_a, 32'h1111_0000);
    ex_dst_alu = 4'h3;
    @(negedge clk); check("R7 mem load over alu", opnd_a, 32'h2222_0000);
    mem_dst_load = 4'h3;
    @(negedge clk); check("R2 mem alu", opnd_a, 32'h3333_0000);
    mem_dst_alu = 4'h3;
    @(negedge clk); check("R7 wb load over alu", opnd_a, 32'h4444_0000);
    wb_dst_load = 4'h3;
    @(negedge clk); check("R2 wb alu", opnd_a, 32'h5555_0000);

    // R3: near-miss IDs do not match
    base(); ex_dst_alu = 4'h0; mem_dst_alu = 4'h3; wb_dst_load = 4'h9;
    @(negedge clk); check("R3 no near match", opnd_a, 32'hAAAA_0001);

    // R1 with forwarding present; R5 B still forwards
    base(); dec_op = 4'h8; ex_dst_alu = 4'h1; mem_dst_alu = 4'h2;
    @(negedge clk);
    check("R1 call pc", opnd_a, 32'h0000_1004);
    check("R5 B forwards on call", opnd_b, 32'h3333_0000);
    dec_op = 4'h7;
    @(negedge clk); check("R1 jump pc", opnd_a, 32'h0000_1004);

    // R6: none ID on both sides
    base(); dec_src_a = 4'hF; dec_src_b = 4'hF;
    ex_dst_alu = 4'hF; mem_dst_load = 4'hF;
    @(negedge clk);
    check("R6 none A", opnd_a, 32'hAAAA_0001);
    check("R6 none B", opnd_b, 32'hBBBB_0002);

    // R8: output follows an input change with no clock edge
    base(); wb_dst_alu = 4'h2;
    #3; check("R8 comb B", opnd_b, 32'h5555_0000);
    wb_alu_val = 32'h5555_9999;
    #3; check("R8 comb follow", opnd_b, 32'h5555_9999);

    // random mix of all requirements R2 R5 R7
    for (int i = 0; i < 3000; i++) begin
      dec_op = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? 4'h8 : 4'h7)
                                           : 4'($urandom_range(0, 6));
      dec_src_a = pick_id(); dec_src_b = pick_id();
      ex_dst_alu = pick_id(); mem_dst_load = pick_id(); mem_dst_alu = pick_id();
      wb_dst_load = pick_id(); wb_dst_alu = pick_id();
      rf_val_a = $urandom; rf_val_b = $urandom; dec_pc_next = $urandom;
      ex_alu_val = $urandom; mem_load_val = $urandom; mem_alu_val = $urandom;
      wb_load_val = $urandom; wb_alu_val = $urandom;
      settle_and_check("R2 R5 rand");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule